// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block is a serial slave on a two-wire bus made of a clock line and an open-drain data line. A host uses it to read and write a bank of 256 byte-wide registers that sits outside the block. Both bus lines are brought into the system clock domain through two-flop synchronizers. Edge detection then finds clock edges, start conditions and stop conditions. The block answers to one 7-bit device address. A strap input picks that address, and the block samples the strap only while reset is held.

In a write, the first byte after the address byte loads an internal 8-bit subaddress pointer. Each later byte goes out on a one-cycle write strobe, together with the pointer as the register address, and the pointer then steps by one. In a read, the block returns the register at the pointer, MSB first, and steps the pointer after each byte. It keeps sending while the host acknowledges. Reads and writes share the pointer, so a write that sends only a subaddress sets the start point for the next read. Subaddress 0x89 is a read-only identity register with a fixed value. Once that byte has been read, the block ignores the host's acknowledge.

Top module: `twowire_regslave`

## Requirements
- R1: A start condition (data falling while clock is high) begins address matching from any state, including partway through a byte. A stop condition (data rising while clock is high) returns the slave to idle.
- R2: The strap input is sampled only while rst_n is low. With strap 0 the device address is 7'b1000101 (write byte 0x8A, read byte 0x89 is not used here; read byte 0x8B). With strap 1 it is 7'b1000100 (write byte 0x88, read byte 0x89). Changing the strap after reset has no effect.
- R3: Bit 0 of the address byte selects the direction: 1 means read, 0 means write. On an address match the slave pulls data low (sda_drv_n = 0) for the whole high time of the ninth clock. On a mismatch it leaves data released until the next start. After reset, data is released.
- R4: After reset the pointer is 0x00. In a write, the byte after the address byte loads the pointer and causes no strobe. Each later byte gives one reg_wr_en pulse, one cycle long, with reg_addr equal to the pointer and reg_wdata equal to the byte. The pointer then steps by one and wraps from 0xFF to 0x00.
- R5: In a write transfer, the slave acknowledges every complete byte it receives in the ninth clock.
- R6: In a read, each byte is driven MSB first. Its value is reg_rdata at the pointer, or the identity value when the pointer is 0x89. The pointer steps after each byte. The slave sends the next byte when the host pulls data low in the ninth clock, and releases data when the host leaves it high.
- R7: The pointer value left at the end of a write is where the next read starts.
- R8: Subaddress 0x89 reads back as the parameter CHIP_ID. A write to 0x89 produces no strobe, but the pointer still steps.
- R9: After the slave has sent the identity byte, it ignores a host acknowledge. It releases data until the next start, so further bytes read back as 0xFF.
- R10: A stop or a repeated start partway through a byte discards that partial byte. There is no strobe and the pointer does not change. Earlier complete bytes keep their effect.
- R11: The slave changes sda_drv_n only while the synchronized clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; the strap is sampled while it is low |
| addr_strap | input | 1 | Selects one of two device addresses |
| scl_in | input | 1 | Bus clock line (asynchronous) |
| sda_in | input | 1 | Bus data line as seen on the wire (asynchronous) |
| sda_drv_n | output | 1 | Open-drain enable for the data line; 0 pulls it low |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_addr | output | 8 | Register address: the pointer, or the write address during a strobe |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data for reg_addr, combinational from the bank |

## Verification
Directed transfers come first. They cover a burst write followed by a read that must continue from the pointer the write left behind. They also cover a pointer wrap at 0xFF, a read across the identity register with the host still acknowledging, and a write aimed at that register. Next come addresses for the other strap value, a strap change without reset, a stop in the middle of a byte and a repeated start in the middle of a byte. These cases separate a slave that decodes the address from one that only counts bytes. They also show whether partial bytes leak into the bank and whether the identity byte really ends the burst. Finally, random write bursts, pointer-only writes and read bursts of random length run against a bench model of the bank and the pointer, and they expose drift in pointer stepping across many transfers.

// File: rtl/twowire_regslave.sv
module twowire_regslave #(
  parameter logic [7:0] CHIP_ID    = 8'hB2,
  parameter logic [7:0] ID_SUBADDR = 8'h89
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_strap,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_drv_n,
  output logic       reg_wr_en,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  input  logic [7:0] reg_rdata
);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK_WAIT, S_ACK, S_TX, S_MACK, S_RLOAD} st_t;
  localparam logic [1:0] K_ADDR = 2'd0, K_SUB = 2'd1, K_DATA = 2'd2;

  logic [2:0] scl_p, sda_p;
  logic       scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
  st_t        st;
  logic [1:0] kind;
  logic [2:0] cnt;
  logic [7:0] sh, ptr, wr_addr;
  logic       rw, id_sent, strap_q;
  logic [7:0] rx_byte, tx_byte;
  logic [6:0] dev_addr;

  assign scl_s    = scl_p[1];
  assign sda_s    = sda_p[1];
  assign scl_rise = scl_s & ~scl_p[2];
  assign scl_fall = ~scl_s & scl_p[2];
  assign start_c  = scl_s & scl_p[2] & ~sda_s & sda_p[2];
  assign stop_c   = scl_s & scl_p[2] & sda_s & ~sda_p[2];
  assign rx_byte  = {sh[6:0], sda_s};
  assign tx_byte  = (ptr == ID_SUBADDR) ? CHIP_ID : reg_rdata;
  assign dev_addr = {6'b100010, ~strap_q};
  assign reg_addr = reg_wr_en ? wr_addr : ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_in};
      sda_p <= {sda_p[1:0], sda_in};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strap_q   <= addr_strap;
      st        <= S_IDLE;
      kind      <= K_ADDR;
      cnt       <= '0;
      sh        <= '0;
      ptr       <= '0;
      wr_addr   <= '0;
      rw        <= 1'b0;
      id_sent   <= 1'b0;
      sda_drv_n <= 1'b1;
      reg_wr_en <= 1'b0;
      reg_wdata <= '0;
    end else begin
      reg_wr_en <= 1'b0;
      if (start_c) begin
        st        <= S_RX;
        kind      <= K_ADDR;
        cnt       <= '0;
        sda_drv_n <= 1'b1;
      end else if (stop_c) begin
        st        <= S_IDLE;
        sda_drv_n <= 1'b1;
      end else begin
        case (st)
          S_RX: if (scl_rise) begin
            sh  <= rx_byte;
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) begin
              st <= S_ACK_WAIT;
              case (kind)
                K_ADDR: begin
                  rw <= sda_s;
                  if (rx_byte[7:1] != dev_addr) st <= S_IDLE;
                end
                K_SUB: ptr <= rx_byte;
                default: begin
                  reg_wr_en <= (ptr != ID_SUBADDR);
                  reg_wdata <= rx_byte;
                  wr_addr   <= ptr;
                  ptr       <= ptr + 8'd1;
                end
              endcase
            end
          end
          S_ACK_WAIT: if (scl_fall) begin
            sda_drv_n <= 1'b0;
            st        <= S_ACK;
          end
          S_ACK: if (scl_fall) begin
            cnt <= '0;
            if (kind == K_ADDR && rw) begin
              sh        <= tx_byte;
              sda_drv_n <= tx_byte[7];
              id_sent   <= (ptr == ID_SUBADDR);
              ptr       <= ptr + 8'd1;
              st        <= S_TX;
            end else begin
              sda_drv_n <= 1'b1;
              kind      <= (kind == K_ADDR) ? K_SUB : K_DATA;
              st        <= S_RX;
            end
          end
          S_TX: if (scl_fall) begin
            if (cnt == 3'd7) begin
              sda_drv_n <= 1'b1;
              st        <= S_MACK;
            end else begin
              cnt       <= cnt + 3'd1;
              sh        <= {sh[6:0], 1'b0};
              sda_drv_n <= sh[6];
            end
          end
          S_MACK: if (scl_rise) st <= (!sda_s && !id_sent) ? S_RLOAD : S_IDLE;
          S_RLOAD: if (scl_fall) begin
            cnt       <= '0;
            sh        <= tx_byte;
            sda_drv_n <= tx_byte[7];
            id_sent   <= (ptr == ID_SUBADDR);
            ptr       <= ptr + 8'd1;
            st        <= S_TX;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/twowire_regslave_chk.sv
module twowire_regslave_chk #(
  parameter logic [7:0] ID_SUBADDR = 8'h89
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_drv_n,
  input logic       reg_wr_en,
  input logic [7:0] reg_addr
);

  // R4
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en);

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> reg_addr == $past(reg_addr) + 8'd1);

  // R8
  id_readonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> reg_addr != ID_SUBADDR);

  // R11
  sda_change_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_drv_n != $past(sda_drv_n)) |-> !$past(scl_s));

endmodule

bind twowire_regslave twowire_regslave_chk #(.ID_SUBADDR(ID_SUBADDR)) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_drv_n(sda_drv_n),
  .reg_wr_en(reg_wr_en), .reg_addr(reg_addr)
);

// File: tb/twowire_regslave_tb_top.sv
module twowire_regslave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int QTR = 8;
  localparam logic [7:0] ID_VAL = 8'hC3;
  localparam logic [7:0] ID_SA  = 8'h89;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       rst_n, strap, m_scl, m_sda;
  logic       sda_drv_n, wr_en;
  logic [7:0] reg_addr, wdata, rdata;
  logic       sda_line;
  logic [7:0] bank [256];
  logic [7:0] exp_bank [256];
  logic [7:0] exp_ptr;
  logic [7:0] wbuf [8];
  int n_chk = 0, n_bad = 0, n_strobe = 0, n_r11 = 0;
  logic prev_drv = 1'b1;

  assign sda_line = m_sda & sda_drv_n;
  assign rdata    = bank[reg_addr];

  twowire_regslave #(.CHIP_ID(ID_VAL), .ID_SUBADDR(ID_SA)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_strap(strap), .scl_in(m_scl), .sda_in(sda_line),
    .sda_drv_n(sda_drv_n), .reg_wr_en(wr_en), .reg_addr(reg_addr),
    .reg_wdata(wdata), .reg_rdata(rdata)
  );

  always @(posedge clk) begin
    if (wr_en) begin
      bank[reg_addr] <= wdata;
      n_strobe <= n_strobe + 1;
    end
    if (rst_n && sda_drv_n != prev_drv && m_scl) n_r11 <= n_r11 + 1;
    prev_drv <= sda_drv_n;
  end

  function automatic logic [7:0] exp_read(input logic [7:0] p);
    return (p == ID_SA) ? ID_VAL : exp_bank[p];
  endfunction

  function automatic logic [7:0] wr_dev(input logic s);
    return s ? 8'h88 : 8'h8A;
  endfunction

  task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic q();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic bitc(input logic b, output logic r);
    q(); m_sda = b; q(); m_scl = 1'b1; q(); r = sda_line; q(); m_scl = 1'b0;
  endtask

  task automatic do_start();
    m_sda = 1'b1; q(); m_scl = 1'b1; q(); m_sda = 1'b0; q(); m_scl = 1'b0;
  endtask

  task automatic do_stop();
    q(); m_sda = 1'b0; q(); m_scl = 1'b1; q(); m_sda = 1'b1; q();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bitc(d[i], r);
    bitc(1'b1, r);
    ack = ~r;
  endtask

  task automatic send_bits(input logic [7:0] d, input int n);
    logic r;
    for (int i = 7; i > 7 - n; i--) bitc(d[i], r);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bitc(1'b1, r);
      d[i] = r;
    end
    bitc(~mack, r);
  endtask

  task automatic do_reset(input logic s);
    rst_n = 1'b0; strap = s; m_scl = 1'b1; m_sda = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    exp_ptr = 8'h00;
  endtask

  // n data bytes from wbuf after the subaddress; hit = address expected to match
  task automatic wr_burst(input logic [7:0] dev, input logic [7:0] sub, input int n, input logic hit);
    logic ack;
    do_start();
    send_byte(dev, ack);
    chk8("R1/R3 address ack", {7'd0, ack}, {7'd0, hit});
    send_byte(sub, ack);
    chk8("R5 subaddress ack", {7'd0, ack}, {7'd0, hit});
    if (hit) exp_ptr = sub;
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], ack);
      chk8("R5 data ack", {7'd0, ack}, {7'd0, hit});
      if (hit) begin
        if (exp_ptr != ID_SA) exp_bank[exp_ptr] = wbuf[k];
        exp_ptr = exp_ptr + 8'd1;
      end
    end
    do_stop();
  endtask

  task automatic rd_burst(input logic [7:0] dev, input int n);
    logic ack, was_id;
    logic [7:0] d;
    do_start();
    send_byte(dev | 8'h01, ack);
    chk8("R3 read address ack", {7'd0, ack}, 8'd1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, d);
      chk8($sformatf("R6/R7 read byte at %h", exp_ptr), d, exp_read(exp_ptr));
      was_id = (exp_ptr == ID_SA);
      exp_ptr = exp_ptr + 8'd1;
      if (was_id && k < n - 1) begin
        recv_byte(1'b0, d);
        chk8("R9 ack after identity ignored", d, 8'hFF);
        break;
      end
    end
    do_stop();
  endtask

  task automatic cmp_bank(input string tag);
    int bad = 0;
    for (int i = 0; i < 256; i++) if (bank[i] !== exp_bank[i]) bad++;
    chk8(tag, bad[7:0], 8'd0);
  endtask

  initial begin
    logic ack;
    int s0;
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < 256; i++) begin
      bank[i] = 8'(i * 37 + 5);
      exp_bank[i] = 8'(i * 37 + 5);
    end
    do_reset(1'b0);
    chk8("R3 released after reset", {7'd0, sda_drv_n}, 8'd1);
    chk8("R4 pointer after reset", reg_addr, 8'h00);
    chk8("R4 no strobe after reset", {7'd0, wr_en}, 8'd0);

    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    wr_burst(8'h8A, 8'h10, 3, 1'b1);
    cmp_bank("R4 burst write contents");
    rd_burst(8'h8A, 2);

    wbuf[0] = 8'hA5; wbuf[1] = 8'h5A;
    wr_burst(8'h8A, 8'hFF, 2, 1'b1);
    cmp_bank("R4 pointer wrap write");
    rd_burst(8'h8A, 1);

    wr_burst(8'h8A, 8'h88, 0, 1'b1);
    rd_burst(8'h8A, 3);

    s0 = n_strobe;
    wbuf[0] = 8'hEE; wbuf[1] = 8'h44;
    wr_burst(8'h8A, ID_SA, 2, 1'b1);
    chk8("R8 one strobe for write across identity", 8'(n_strobe - s0), 8'd1);
    cmp_bank("R8 identity write skipped");
    rd_burst(8'h8A, 1);

    s0 = n_strobe;
    wbuf[0] = 8'h01; wbuf[1] = 8'h02;
    wr_burst(8'h88, 8'h50, 2, 1'b0);
    chk8("R3 mismatch gives no strobe", 8'(n_strobe - s0), 8'd0);

    do_start();
    send_byte(8'h8A, ack);
    send_byte(8'h20, ack);
    send_byte(8'h5A, ack);
    exp_ptr = 8'h21; exp_bank[8'h20] = 8'h5A;
    send_bits(8'hF0, 4);
    do_stop();
    cmp_bank("R10 partial byte before stop discarded");
    rd_burst(8'h8A, 1);

    do_start();
    send_byte(8'h8A, ack);
    send_byte(8'h30, ack);
    send_bits(8'h00, 3);
    exp_ptr = 8'h30;
    wbuf[0] = 8'h77;
    wr_burst(8'h8A, 8'h40, 1, 1'b1);
    cmp_bank("R1/R10 repeated start mid-byte");

    strap = 1'b1;
    wr_burst(8'h88, 8'h60, 0, 1'b0);
    rd_burst(8'h8A, 1);
    chk8("R2 strap change without reset ignored", exp_ptr, 8'h42);

    do_reset(1'b1);
    wr_burst(8'h8A, 8'h61, 0, 1'b0);
    wbuf[0] = 8'h99;
    wr_burst(8'h88, 8'h61, 1, 1'b1);
    cmp_bank("R2 strap 1 address write");
    rd_burst(8'h88, 1);

    for (int it = 0; it < 30; it++) begin
      int op = int'($urandom_range(0, 2));
      if (op == 0) begin
        int n = int'($urandom_range(1, 5));
        for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
        wr_burst(wr_dev(1'b1), 8'($urandom), n, 1'b1);
      end else if (op == 1) begin
        wr_burst(wr_dev(1'b1), 8'($urandom), 0, 1'b1);
      end else begin
        rd_burst(wr_dev(1'b1), int'($urandom_range(1, 4)));
      end
    end
    cmp_bank("R4/R6 random traffic bank");

    chk8("R11 drive changes only while clock low", 8'(n_r11), 8'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule